// File: doc/BRIEF.md
# Shared Bus Mode Selector

This block sits between a host register port and a shared external bus. It decides whether the bus carries memory-mapped register traffic, flash access or FPGA configuration traffic. Two host-driven mode lines pick the mode. A host-driven reset line asks for a reset of the sub-interfaces. All three lines are filtered, so a change only takes effect once the new value has been seen on enough consecutive clocks.

The encoding is fail-safe. Lines that float high while the host is not driving them select memory-mapped mode. A small register set gives the host four things:
- a read-only version word;
- a switch that falls back to an older line encoding;
- an active-low output-enable bit;
- a bit that resets the downstream modules.

The control register is kept in three copies. It is read through a majority vote, and each copy is rewritten with the voted value on every clock.

The block drives select and reset outputs to the flash and configuration sub-interfaces. It also drives per-bit value and enable outputs for the bus control lines.

Top module: `bus_mode_sel`

## Requirements
- R1: With the new encoding, filtered mode lines 2'b01 select flash (`mode_code` 1, `flash_sel` 1), 2'b10 select configuration (`mode_code` 2, `cfg_sel` 1), and 2'b00 and 2'b11 select memory-mapped mode (`mode_code` 0, both selects 0).
- R2: After reset the block is in memory-mapped mode with the new encoding, the control register is 0 and the filtered reset line is inactive. Mode lines that stay at 2'b11 keep it in memory-mapped mode.
- R3: A new mode-line value takes effect on the clock edge at which it has been sampled on 8 consecutive edges. A value held for fewer edges changes nothing.
- R4: The reset line is filtered the same way. `sub_rst` is 1 while the filtered reset line is 1.
- R5: Writing 0x0000001D to address 0xBF02 selects the legacy encoding, and any other value written there selects the new one. Reading 0xBF02 returns the legacy flag in bit 0.
- R6: With the legacy encoding, 2'b01 selects flash, 2'b11 selects configuration, and 2'b00 and 2'b10 select memory-mapped mode.
- R7: `flash_rst` is 1 whenever flash mode is not selected, and also whenever `sub_rst` is 1.
- R8: Address 0xBF00 reads the version word {day[7:0], month[3:0], year[3:0], major[7:0], minor[7:0]}. With the default parameters this is 0x12290208.
- R9: The control register is at 0xBF04 and its bit 4 is the active-low output enable.
  - When bit 4 is 1: `ctrl_en` is 8'hC0, `ctrl_val` is 0 and `data_oe` is 0.
  - When bit 4 is 0: `ctrl_en` is 8'hFF, `ctrl_val` equals `ctrl_drv` and `data_oe` is 1.
- R10: Bit 5 of the control register drives `sub_rst` to 1 for as long as it is set.
- R11: The control register reads back the last value written to its low 8 bits, through a majority vote of three stored copies.
- R12: Reads of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_raw | input | 2 | Unfiltered mode lines from the host |
| bus_rst_raw | input | 1 | Unfiltered reset request line from the host |
| reg_addr | input | 16 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ctrl_drv | input | 8 | Bus control values from the active sub-interface |
| ctrl_val | output | 8 | Bus control values to drive |
| ctrl_en | output | 8 | Per-bit drive enable for the bus control lines |
| data_oe | output | 1 | Drive enable for the bus data lines |
| mode_code | output | 2 | Selected mode: 0 memory-mapped, 1 flash, 2 configuration |
| flash_sel | output | 1 | Flash sub-interface selected |
| cfg_sel | output | 1 | Configuration sub-interface selected |
| flash_rst | output | 1 | Reset to the flash sub-interface |
| sub_rst | output | 1 | Reset to the downstream modules |

## Verification
The mode lines are walked through all four codes under both encodings, and each code is held long enough to be accepted. This tells the two decode tables apart and shows that both idle codes fall back to memory-mapped mode. Short bursts of 5 cycles on the mode lines and of 3 cycles on the reset line are set against runs of 9 or more cycles, which exposes an off-by-one in the stability count. The control-register patterns toggle the output-enable and firmware-reset bits separately and use a mixed value, so a swapped bit or a broken vote shows up in the read data and at the pins.

// File: rtl/busmode_pkg.sv
package busmode_pkg;

    typedef enum logic [1:0] {
        BM_MMAP  = 2'd0,
        BM_FLASH = 2'd1,
        BM_CFG   = 2'd2
    } bus_mode_e;

    localparam logic [31:0] LEGACY_KEY = 32'h0000_001D;

    typedef struct packed {
        logic [7:0] day;
        logic [3:0] month;
        logic [3:0] year;
        logic [7:0] major;
        logic [7:0] minor;
    } version_s;

    // New encoding: idle-high and all-low lines both fall to memory-mapped.
    // Legacy encoding: configuration sits on 2'b11.
    function automatic bus_mode_e decode_lines(input logic [1:0] lines, input logic legacy);
        bus_mode_e m;
        m = BM_MMAP;
        if (lines == 2'b01) begin
            m = BM_FLASH;
        end else if (!legacy && lines == 2'b10) begin
            m = BM_CFG;
        end else if (legacy && lines == 2'b11) begin
            m = BM_CFG;
        end
        return m;
    endfunction

    function automatic logic [31:0] majority32(input logic [31:0] a, input logic [31:0] b,
                                              input logic [31:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/bm_line_filter.sv
module bm_line_filter #(
    parameter int               W       = 2,
    parameter int               DEPTH   = 8,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);
    localparam int              CNT_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(DEPTH - 1);

    logic [W-1:0]     cand;
    logic [CNT_W-1:0] run;

    // run holds (consecutive equal samples - 1), saturating at DEPTH-1
    always_ff @(posedge clk) begin
        if (rst) begin
            cand <= RST_VAL;
            filt <= RST_VAL;
            run  <= SAT;
        end else if (raw != cand) begin
            cand <= raw;
            run  <= '0;
        end else begin
            if (run != SAT) begin
                run <= run + 1'b1;
            end
            if (run >= SAT - 1'b1) begin
                filt <= cand;
            end
        end
    end

    // R3
    filt_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt) |-> $past(raw) == filt);

endmodule

// File: rtl/bm_regs.sv
module bm_regs
    import busmode_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               DATA_W    = 32,
    parameter int               CTRL_W    = 8,
    parameter logic [ADDR_W-1:0] VER_ADDR  = 16'hBF00,
    parameter logic [ADDR_W-1:0] LEG_ADDR  = 16'hBF02,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hBF04,
    parameter logic [DATA_W-1:0] VERSION   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CTRL_W-1:0] ctrl,
    output logic              legacy
);
    localparam int COPIES = 3;

    logic [CTRL_W-1:0] copy_q [COPIES];
    logic              ctrl_wr;

    assign ctrl_wr = we && (addr == CTRL_ADDR);
    assign ctrl    = CTRL_W'(majority32(32'(copy_q[0]), 32'(copy_q[1]), 32'(copy_q[2])));

    // Each copy is written together, otherwise refreshed from the vote
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst) begin
                copy_q[i] <= '0;
            end else if (ctrl_wr) begin
                copy_q[i] <= wdata[CTRL_W-1:0];
            end else begin
                copy_q[i] <= ctrl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            legacy <= 1'b0;
        end else if (we && addr == LEG_ADDR) begin
            legacy <= (32'(wdata) == LEGACY_KEY);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == VER_ADDR) begin
            rdata = VERSION;
        end else if (addr == LEG_ADDR) begin
            rdata = DATA_W'(legacy);
        end else if (addr == CTRL_ADDR) begin
            rdata = DATA_W'(ctrl);
        end
    end

    // R5
    legacy_key_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == LEG_ADDR) |=> legacy == ($past(32'(wdata)) == LEGACY_KEY));

    // R11
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> ctrl == $past(wdata[CTRL_W-1:0]));

    // R11
    copies_agree_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> (copy_q[0] == copy_q[1]) && (copy_q[1] == copy_q[2]));

endmodule

// File: rtl/bus_mode_sel.sv
module bus_mode_sel
    import busmode_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         DATA_W    = 32,
    parameter int         CTRL_W    = 8,
    parameter int         STABLE_N  = 8,
    parameter int         OE_BIT    = 4,
    parameter int         FWRST_BIT = 5,
    parameter logic [7:0] VER_DAY   = 8'd18,
    parameter logic [3:0] VER_MONTH = 4'd2,
    parameter logic [3:0] VER_YEAR  = 4'd9,
    parameter logic [7:0] VER_MAJOR = 8'd2,
    parameter logic [7:0] VER_MINOR = 8'd8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_raw,
    input  logic              bus_rst_raw,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CTRL_W-1:0] ctrl_drv,
    output logic [CTRL_W-1:0] ctrl_val,
    output logic [CTRL_W-1:0] ctrl_en,
    output logic              data_oe,
    output logic [1:0]        mode_code,
    output logic              flash_sel,
    output logic              cfg_sel,
    output logic              flash_rst,
    output logic              sub_rst
);
    // The two top control bits stay driven low while outputs are disabled
    localparam int                KEEP_N   = 2;
    localparam logic [CTRL_W-1:0] KEEP_MSK = {{KEEP_N{1'b1}}, {(CTRL_W-KEEP_N){1'b0}}};
    localparam version_s          VER_S    = '{day: VER_DAY, month: VER_MONTH, year: VER_YEAR,
                                               major: VER_MAJOR, minor: VER_MINOR};

    logic [1:0]        lines_f;
    logic              rstline_f;
    logic [CTRL_W-1:0] ctrl;
    logic              legacy;
    logic              oe_n;
    bus_mode_e         mode;

    bm_line_filter #(.W(2), .DEPTH(STABLE_N), .RST_VAL(2'b11)) u_mode_filt (
        .clk (clk), .rst (rst), .raw (mode_raw), .filt (lines_f)
    );

    bm_line_filter #(.W(1), .DEPTH(STABLE_N), .RST_VAL(1'b0)) u_rst_filt (
        .clk (clk), .rst (rst), .raw (bus_rst_raw), .filt (rstline_f)
    );

    bm_regs #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CTRL_W (CTRL_W),
        .VERSION (DATA_W'(VER_S))
    ) u_regs (
        .clk (clk), .rst (rst), .addr (reg_addr), .we (reg_we), .wdata (reg_wdata),
        .rdata (reg_rdata), .ctrl (ctrl), .legacy (legacy)
    );

    assign mode      = decode_lines(lines_f, legacy);
    assign mode_code = mode;
    assign flash_sel = (mode == BM_FLASH);
    assign cfg_sel   = (mode == BM_CFG);
    assign sub_rst   = rstline_f | ctrl[FWRST_BIT];
    assign flash_rst = sub_rst | (mode != BM_FLASH);

    assign oe_n     = ctrl[OE_BIT];
    assign data_oe  = ~oe_n;
    assign ctrl_en  = oe_n ? KEEP_MSK : '1;
    assign ctrl_val = oe_n ? '0 : ctrl_drv;

    // R1
    one_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_sel, cfg_sel}));

    // R7
    flash_held_chk: assert property (@(posedge clk) disable iff (rst)
        !flash_sel |-> flash_rst);

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (ctrl_en == KEEP_MSK) && (ctrl_val == '0));

    // R10
    fw_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 16'hBF04 && reg_wdata[FWRST_BIT]) |=> sub_rst);

endmodule

// File: tb/bus_mode_sel_test.sv
module bus_mode_sel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_raw = 2'b11;
    logic        bus_rst_raw = 1'b0;
    logic [15:0] reg_addr = 16'hBF04;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  ctrl_drv = 8'h5A;
    logic [7:0]  ctrl_val, ctrl_en;
    logic        data_oe, flash_sel, cfg_sel, flash_rst, sub_rst;
    logic [1:0]  mode_code;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    bus_mode_sel uut (
        .clk (clk), .rst (rst), .mode_raw (mode_raw), .bus_rst_raw (bus_rst_raw),
        .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .ctrl_drv (ctrl_drv), .ctrl_val (ctrl_val), .ctrl_en (ctrl_en), .data_oe (data_oe),
        .mode_code (mode_code), .flash_sel (flash_sel), .cfg_sel (cfg_sel),
        .flash_rst (flash_rst), .sub_rst (sub_rst)
    );

    // Reference model: last 8 samples of each line, accepted when all equal
    logic [1:0] mhist[$];
    logic       rhist[$];
    logic [1:0] m_lines;
    logic       m_rline;
    logic       m_legacy;
    logic [7:0] m_ctrl;

    always @(posedge clk) begin
        if (rst) begin
            mhist = {}; rhist = {};
            for (int i = 0; i < 8; i++) begin
                mhist.push_back(2'b11);
                rhist.push_back(1'b0);
            end
            m_lines = 2'b11; m_rline = 1'b0; m_legacy = 1'b0; m_ctrl = 8'h00;
        end else begin
            bit all_m, all_r;
            void'(mhist.pop_front()); mhist.push_back(mode_raw);
            void'(rhist.pop_front()); rhist.push_back(bus_rst_raw);
            all_m = 1; all_r = 1;
            foreach (mhist[i]) if (mhist[i] != mode_raw) all_m = 0;
            foreach (rhist[i]) if (rhist[i] != bus_rst_raw) all_r = 0;
            if (all_m) m_lines = mode_raw;
            if (all_r) m_rline = bus_rst_raw;
            if (reg_we && reg_addr == 16'hBF02) m_legacy = (reg_wdata == 32'h1D);
            if (reg_we && reg_addr == 16'hBF04) m_ctrl = reg_wdata[7:0];
        end
    end

    function automatic int exp_mode();
        if (m_lines == 2'b01) return 1;
        if (!m_legacy && m_lines == 2'b10) return 2;
        if (m_legacy && m_lines == 2'b11) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_rdata();
        case (reg_addr)
            16'hBF00: return 32'h1229_0208;
            16'hBF02: return {31'd0, m_legacy};
            16'hBF04: return {24'd0, m_ctrl};
            default:  return 32'd0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", what, $time, act, exp);
        end
    endtask

    // Compare every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            int em;
            logic e_sub;
            em = exp_mode();
            e_sub = m_rline | m_ctrl[5];
            chk("R1 R3 R6 mode_code", 32'(mode_code), 32'(em));
            chk("R1 flash_sel", 32'(flash_sel), 32'(em == 1));
            chk("R1 cfg_sel", 32'(cfg_sel), 32'(em == 2));
            chk("R4 R10 sub_rst", 32'(sub_rst), 32'(e_sub));
            chk("R7 flash_rst", 32'(flash_rst), 32'(e_sub | (em != 1)));
            chk("R9 data_oe", 32'(data_oe), 32'(!m_ctrl[4]));
            chk("R9 ctrl_en", 32'(ctrl_en), m_ctrl[4] ? 32'hC0 : 32'hFF);
            chk("R9 ctrl_val", 32'(ctrl_val), m_ctrl[4] ? 32'h0 : 32'(ctrl_drv));
            chk("R5 R8 R11 R12 reg_rdata", reg_rdata, exp_rdata());
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_at(input logic [15:0] a);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                cyc(4);
                rst = 1'b0;
                cyc(1);
                // R2: reset state with idle-high lines
                chk("R2 mode_code after reset", 32'(mode_code), 32'd0);
                chk("R2 sub_rst after reset", 32'(sub_rst), 32'd0);
                chk("R2 flash_rst after reset", 32'(flash_rst), 32'd1);
                chk("R2 control readback", reg_rdata, 32'd0);
                cyc(10);
                // R1: new encoding, each code held long enough
                mode_raw = 2'b01; cyc(10);
                mode_raw = 2'b10; cyc(10);
                mode_raw = 2'b00; cyc(10);
                mode_raw = 2'b01; cyc(10);
                mode_raw = 2'b11; cyc(10);
                // R3: short bursts must not be accepted; exactly 8 must
                mode_raw = 2'b01; cyc(5);
                mode_raw = 2'b11; cyc(10);
                mode_raw = 2'b10; cyc(7);
                mode_raw = 2'b00; cyc(8);
                mode_raw = 2'b01; cyc(8);
                // R4: reset line glitch vs. held request
                bus_rst_raw = 1'b1; cyc(3);
                bus_rst_raw = 1'b0; cyc(10);
                bus_rst_raw = 1'b1; cyc(9);
                bus_rst_raw = 1'b0; cyc(10);
                // R8, R12
                rd_at(16'hBF00);
                rd_at(16'h1234);
                rd_at(16'hBF03);
                // R9: output enable bit
                wr(16'hBF04, 32'h10);
                ctrl_drv = 8'hFF; cyc(3);
                ctrl_drv = 8'h3C; cyc(3);
                wr(16'hBF04, 32'h00);
                cyc(3);
                // R10: firmware reset bit
                wr(16'hBF04, 32'h20); cyc(4);
                wr(16'hBF04, 32'h00); cyc(4);
                // R11: mixed value and upper bits dropped
                wr(16'hBF04, 32'hFFFF_FFA5); cyc(4);
                wr(16'hBF04, 32'h0000_0042); cyc(4);
                // R5, R6: legacy encoding
                wr(16'hBF02, 32'h1D);
                rd_at(16'hBF02);
                mode_raw = 2'b11; cyc(10);
                mode_raw = 2'b10; cyc(10);
                mode_raw = 2'b01; cyc(10);
                mode_raw = 2'b00; cyc(10);
                mode_raw = 2'b11; cyc(10);
                wr(16'hBF02, 32'h1E);
                rd_at(16'hBF02);
                cyc(10);
                wr(16'hBF02, 32'h11D);
                cyc(5);
                rd_at(16'hBF04);
                cyc(5);
            end
            begin
                cyc(20000);
                mismatched++;
                compared++;
                $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule